// File: doc/BRIEF.md
# TDM Time Slot Interchange Core

This block moves byte-wide time slots between parallel TDM streams. One clock cycle carries one channel slot. In that cycle each input stream presents one byte that is already deserialised, and each output stream produces one byte. A frame pulse marks channel 0. The default build has 4 input streams, 4 output streams and 32 channels per frame. Every input byte is stored in a data memory. The memory holds the three most recent frames, one bank per frame in rotation.

The connection memory holds one 16-bit word for each output stream and channel. The word's mode field picks one of four behaviours:
- copy an input slot with a fixed two-frame delay,
- copy an input slot with the smallest delay possible,
- send a byte that the processor supplies,
- leave that single channel undriven.

A synchronous processor bus gives access to the connection memory and to a small control register. The control register holds the output-standby enable and the block-programming controls. The block-programming engine fills the whole connection memory with one mode pattern and then clears its own control bits.

Top module: `tsi_switch`

## Requirements
- R1: After reset the control register reads 0x0000 and every connection word reads 0x0000. No output lane is driven, and an undriven lane always shows byte 0x00.
- R2: The cycle in which frame_pulse is high is channel 0 of a new frame, and each following cycle is the next channel. A new pulse restarts at channel 0 even in the middle of a frame. The output for a channel appears in the cycle after that channel's input cycle.
- R3: Mode 01 (bits 15:14) is constant delay. The channel outputs the byte that entered on the source stream (bits 6:5) and source channel (bits 4:0) two frames earlier.
- R4: Mode 00 is variable delay. If the source channel number is below the current output channel, the channel outputs this frame's byte. Otherwise it outputs the previous frame's byte.
- R5: Mode 10 is processor mode. The channel outputs bits 7:0 of its connection word in every frame.
- R6: Mode 11 leaves only that output channel undriven (drive low, byte 0x00). Other channels of the same stream are not affected.
- R7: When out_enable_pin is low and control bit 0 (standby enable) is low, no lane is driven. If either one is high, the per-channel modes apply.
- R8: An address with bit 7 set selects a connection word, with bits 6:5 giving the output stream and bits 4:0 the channel. Address 0x00 is the control register. A read returns the data one cycle later. A connection word reads back as written, except that bits 13:8 read as zero.
- R9: Control bits 8:7 hold a pattern, bit 9 arms block programming and bit 10 starts it. Writing 1 to both bit 9 and bit 10 sets every connection word to the pattern in bits 15:14 and zero in bits 13:0, within 64 cycles. When this is done, bits 10:7 read as zero.
- R10: Writing bit 10 without bit 9 has no effect. Bit 10 reads as zero and the connection memory is unchanged.
- R11: A connection write issued in channel slot c first affects the output of slot c+1. Slot c itself still uses the old word.
- R12: Several output channels that name the same source slot all carry that same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one channel slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frame_pulse | input | 1 | High in the cycle of channel 0 |
| in_bytes | input | 32 | One byte per input stream, stream s at bits 8s+7:8s |
| out_enable_pin | input | 1 | Master output enable |
| cpu_sel | input | 1 | Processor access strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 8 | Processor address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Read data, valid the cycle after a read |
| out_bytes | output | 32 | One byte per output stream |
| out_drive | output | 4 | Per-stream drive enable for the current channel |

## Verification
The hardest cases to reach are the frame-relative ones. These are a variable-delay source whose channel is equal to or above the output channel, and a constant-delay source read from the bank that is two rotations old. They only show correct values once several frames of distinct, frame-numbered input bytes have been captured. The bench therefore drives a byte pattern that depends on frame, stream and channel through back-to-back frames, and checks the configured channels only from the third frame on. Processor writes that land mid-frame, and a frame pulse that cuts a frame short, are issued inside the slot loop. This keeps the frame sequence unbroken while hitting those cases.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    // connection word bits kept on write; bits 13:8 are reserved
    localparam logic [15:0] CM_KEEP_MASK = 16'hC0FF;

    typedef enum logic [1:0] {
        MODE_VAR   = 2'b00,
        MODE_CONST = 2'b01,
        MODE_PROC  = 2'b10,
        MODE_HIZ   = 2'b11
    } chan_mode_e;

    typedef struct packed {
        logic       blk_en;
        logic       blk_prog;
        logic [1:0] blk_pat;
        logic       standby;
    } ctrl_t;

    // three-bank rotation of the data memory
    function automatic logic [1:0] bank_inc(input logic [1:0] b);
        return (b == 2'd2) ? 2'd0 : b + 2'd1;
    endfunction

endpackage

// File: rtl/tsi_timing.sv
module tsi_timing
    import tsi_pkg::*;
#(
    parameter int NCHAN = 32,
    localparam int CW = $clog2(NCHAN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_pulse,
    output logic [CW-1:0] cur_slot,
    output logic [1:0]    cur_bank
);

    typedef struct packed {
        logic [CW-1:0] slot;
        logic [1:0]    bank;
    } tstate_t;

    tstate_t st_d, st_q;

    always_comb begin
        cur_slot    = frame_pulse ? '0 : st_q.slot;
        cur_bank    = frame_pulse ? bank_inc(st_q.bank) : st_q.bank;
        st_d.bank   = cur_bank;
        st_d.slot   = (cur_slot == CW'(NCHAN - 1)) ? '0 : cur_slot + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R2: a frame pulse makes the following cycle channel 1
    a_r2_slot_restart: assert property (@(posedge clk) disable iff (rst)
        frame_pulse |=> (st_q.slot == CW'(1)));

    // R2: bank rotation only ever uses three banks
    a_r2_bank_range: assert property (@(posedge clk) disable iff (rst)
        st_q.bank != 2'd3);

endmodule

// File: rtl/tsi_dmem.sv
module tsi_dmem
    import tsi_pkg::*;
#(
    parameter int NSTREAM = 4,
    parameter int NCHAN   = 32,
    localparam int SW = $clog2(NSTREAM),
    localparam int CW = $clog2(NCHAN)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [CW-1:0]                 wr_slot,
    input  logic [1:0]                    wr_bank,
    input  logic [NSTREAM*8-1:0]          wr_bytes,
    input  logic [NSTREAM-1:0][SW-1:0]    rd_stream,
    input  logic [NSTREAM-1:0][CW-1:0]    rd_chan,
    input  logic [NSTREAM-1:0]            rd_const,
    output logic [NSTREAM-1:0][7:0]       rd_bytes
);

    logic [7:0]                mem_q [3][NSTREAM][NCHAN];
    logic [NSTREAM-1:0][1:0]   rd_bank;

    always_ff @(posedge clk) begin
        for (int s = 0; s < NSTREAM; s++) begin
            mem_q[wr_bank][s][wr_slot] <= wr_bytes[s*8 +: 8];
        end
    end

    always_comb begin
        for (int s = 0; s < NSTREAM; s++) begin
            if (rd_const[s])
                rd_bank[s] = bank_inc(wr_bank);
            else if (rd_chan[s] < wr_slot)
                rd_bank[s] = wr_bank;
            else
                rd_bank[s] = bank_inc(bank_inc(wr_bank));
            rd_bytes[s] = mem_q[rd_bank[s]][rd_stream[s]][rd_chan[s]];
        end
    end

    for (genvar g = 0; g < NSTREAM; g++) begin : g_chk
        // R3: constant delay never reads the bank being filled
        a_r3_const_not_live: assert property (@(posedge clk) disable iff (rst)
            rd_const[g] |-> (rd_bank[g] != wr_bank));
        // R4: a source slot not yet written this frame comes from an older bank
        a_r4_unwritten_old: assert property (@(posedge clk) disable iff (rst)
            (!rd_const[g] && (rd_chan[g] >= wr_slot)) |-> (rd_bank[g] != wr_bank));
    end

endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem
    import tsi_pkg::*;
#(
    parameter int NSTREAM = 4,
    parameter int NCHAN   = 32,
    localparam int SW = $clog2(NSTREAM),
    localparam int CW = $clog2(NCHAN),
    localparam int IW = SW + CW
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [CW-1:0]              slot,
    input  logic                       cpu_we,
    input  logic [IW-1:0]              cpu_idx,
    input  logic [15:0]                cpu_wdata,
    output logic [15:0]                cpu_rword,
    input  logic                       blk_go,
    input  logic [1:0]                 blk_pat,
    output logic                       blk_done,
    output logic [NSTREAM-1:0][1:0]    slot_mode,
    output logic [NSTREAM-1:0][7:0]    slot_low
);

    logic [15:0]   cm_q [NSTREAM][NCHAN];
    logic [15:0]   cm_d [NSTREAM][NCHAN];
    logic [CW-1:0] blk_idx_q, blk_idx_d;
    logic [SW-1:0] idx_stream;
    logic [CW-1:0] idx_chan;

    assign idx_stream = cpu_idx[IW-1:CW];
    assign idx_chan   = cpu_idx[CW-1:0];

    always_comb begin
        cm_d      = cm_q;
        blk_idx_d = '0;
        blk_done  = 1'b0;
        if (blk_go) begin
            // one channel index per cycle, all streams in parallel
            for (int s = 0; s < NSTREAM; s++) begin
                cm_d[s][blk_idx_q] = {blk_pat, 14'b0};
            end
            blk_done  = (blk_idx_q == CW'(NCHAN - 1));
            blk_idx_d = blk_done ? '0 : blk_idx_q + 1'b1;
        end else if (cpu_we) begin
            cm_d[idx_stream][idx_chan] = cpu_wdata & CM_KEEP_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cm_q      <= '{default: '0};
            blk_idx_q <= '0;
        end else begin
            cm_q      <= cm_d;
            blk_idx_q <= blk_idx_d;
        end
    end

    always_comb begin
        cpu_rword = cm_q[idx_stream][idx_chan];
        for (int s = 0; s < NSTREAM; s++) begin
            slot_mode[s] = cm_q[s][slot][15:14];
            slot_low[s]  = cm_q[s][slot][7:0];
        end
    end

    // R9: the engine restarts from index 0 after finishing
    a_r9_idx_wrap: assert property (@(posedge clk) disable iff (rst)
        blk_done |=> (blk_idx_q == '0));

    // R10: with the engine idle and no write, the addressed word holds
    a_r10_word_hold: assert property (@(posedge clk) disable iff (rst)
        (!blk_go && !cpu_we) |=> $stable(cpu_rword) || $changed(cpu_idx));

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int NSTREAM = 4,
    parameter int NCHAN   = 32,
    localparam int SW = $clog2(NSTREAM),
    localparam int CW = $clog2(NCHAN),
    localparam int IW = SW + CW,
    localparam int AW = IW + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_pulse,
    input  logic [NSTREAM*8-1:0]  in_bytes,
    input  logic                  out_enable_pin,
    input  logic                  cpu_sel,
    input  logic                  cpu_wr,
    input  logic [AW-1:0]         cpu_addr,
    input  logic [15:0]           cpu_wdata,
    output logic [15:0]           cpu_rdata,
    output logic [NSTREAM*8-1:0]  out_bytes,
    output logic [NSTREAM-1:0]    out_drive
);

    typedef struct packed {
        ctrl_t                 ctrl;
        logic [15:0]           rdata;
        logic [NSTREAM*8-1:0]  obytes;
        logic [NSTREAM-1:0]    odrv;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [CW-1:0]              cur_slot;
    logic [1:0]                 cur_bank;
    logic [NSTREAM-1:0][1:0]    slot_mode;
    logic [NSTREAM-1:0][7:0]    slot_low;
    logic [NSTREAM-1:0][SW-1:0] rd_stream;
    logic [NSTREAM-1:0][CW-1:0] rd_chan;
    logic [NSTREAM-1:0]         rd_const;
    logic [NSTREAM-1:0][7:0]    rd_bytes;
    logic [15:0]                cm_rword;
    logic                       blk_done;
    logic                       blk_go;
    logic                       sel_cm, sel_ctrl, cm_we, master_on;

    assign sel_cm   = cpu_addr[AW-1];
    assign sel_ctrl = (cpu_addr == '0);
    assign cm_we    = cpu_sel && cpu_wr && sel_cm;
    assign blk_go   = st_q.ctrl.blk_en && st_q.ctrl.blk_prog;

    tsi_timing #(.NCHAN(NCHAN)) u_timing (
        .clk         (clk),
        .rst         (rst),
        .frame_pulse (frame_pulse),
        .cur_slot    (cur_slot),
        .cur_bank    (cur_bank)
    );

    tsi_cmem #(.NSTREAM(NSTREAM), .NCHAN(NCHAN)) u_cmem (
        .clk       (clk),
        .rst       (rst),
        .slot      (cur_slot),
        .cpu_we    (cm_we),
        .cpu_idx   (cpu_addr[IW-1:0]),
        .cpu_wdata (cpu_wdata),
        .cpu_rword (cm_rword),
        .blk_go    (blk_go),
        .blk_pat   (st_q.ctrl.blk_pat),
        .blk_done  (blk_done),
        .slot_mode (slot_mode),
        .slot_low  (slot_low)
    );

    always_comb begin
        for (int s = 0; s < NSTREAM; s++) begin
            rd_stream[s] = slot_low[s][CW+SW-1:CW];
            rd_chan[s]   = slot_low[s][CW-1:0];
            rd_const[s]  = (chan_mode_e'(slot_mode[s]) == MODE_CONST);
        end
    end

    tsi_dmem #(.NSTREAM(NSTREAM), .NCHAN(NCHAN)) u_dmem (
        .clk       (clk),
        .rst       (rst),
        .wr_slot   (cur_slot),
        .wr_bank   (cur_bank),
        .wr_bytes  (in_bytes),
        .rd_stream (rd_stream),
        .rd_chan   (rd_chan),
        .rd_const  (rd_const),
        .rd_bytes  (rd_bytes)
    );

    always_comb begin
        st_d      = st_q;
        master_on = out_enable_pin || st_q.ctrl.standby;

        // control register write; enable only sticks when armed
        if (cpu_sel && cpu_wr && sel_ctrl) begin
            st_d.ctrl.standby  = cpu_wdata[0];
            st_d.ctrl.blk_pat  = cpu_wdata[8:7];
            st_d.ctrl.blk_prog = cpu_wdata[9];
            st_d.ctrl.blk_en   = cpu_wdata[10] && cpu_wdata[9];
        end
        if (blk_done) begin
            st_d.ctrl.blk_en   = 1'b0;
            st_d.ctrl.blk_prog = 1'b0;
            st_d.ctrl.blk_pat  = 2'b00;
        end

        if (cpu_sel && !cpu_wr) begin
            if (sel_cm)
                st_d.rdata = cm_rword;
            else if (sel_ctrl)
                st_d.rdata = {5'b0, st_q.ctrl.blk_en, st_q.ctrl.blk_prog,
                              st_q.ctrl.blk_pat, 6'b0, st_q.ctrl.standby};
            else
                st_d.rdata = '0;
        end

        for (int s = 0; s < NSTREAM; s++) begin
            st_d.odrv[s] = master_on && (chan_mode_e'(slot_mode[s]) != MODE_HIZ);
            if (!st_d.odrv[s])
                st_d.obytes[s*8 +: 8] = 8'h00;
            else if (chan_mode_e'(slot_mode[s]) == MODE_PROC)
                st_d.obytes[s*8 +: 8] = slot_low[s];
            else
                st_d.obytes[s*8 +: 8] = rd_bytes[s];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cpu_rdata = st_q.rdata;
    assign out_bytes = st_q.obytes;
    assign out_drive = st_q.odrv;

    // R7: both master enables low silence every lane in the next cycle
    a_r7_master_off: assert property (@(posedge clk) disable iff (rst)
        (!out_enable_pin && !st_q.ctrl.standby) |=> (out_drive == '0));

    // R9: completion clears the enable, arm and pattern bits
    a_r9_self_clear: assert property (@(posedge clk) disable iff (rst)
        blk_done |=> (!st_q.ctrl.blk_en && !st_q.ctrl.blk_prog && st_q.ctrl.blk_pat == 2'b00));

    // R10: the start bit is never held without the arm bit
    a_r10_en_needs_prog: assert property (@(posedge clk) disable iff (rst)
        st_q.ctrl.blk_en |-> st_q.ctrl.blk_prog);

    for (genvar g = 0; g < NSTREAM; g++) begin : g_lane_chk
        // R6: a high-impedance channel is not driven in its output cycle
        a_r6_hiz_lane: assert property (@(posedge clk) disable iff (rst)
            (slot_mode[g] == 2'b11) |=> !out_drive[g]);
        // R1: an undriven lane carries zero
        a_r1_quiet_zero: assert property (@(posedge clk) disable iff (rst)
            !out_drive[g] |-> (out_bytes[g*8 +: 8] == 8'h00));
    end

endmodule

// File: tb/tb_tsi_switch.sv
module tb_tsi_switch;

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_pulse;
    logic [31:0] in_bytes;
    logic        out_enable_pin;
    logic        cpu_sel, cpu_wr;
    logic [7:0]  cpu_addr;
    logic [15:0] cpu_wdata;
    logic [15:0] cpu_rdata;
    logic [31:0] out_bytes;
    logic [3:0]  out_drive;

    always #10 clk = ~clk;

    tsi_switch dut (
        .clk            (clk),
        .rst            (rst),
        .frame_pulse    (frame_pulse),
        .in_bytes       (in_bytes),
        .out_enable_pin (out_enable_pin),
        .cpu_sel        (cpu_sel),
        .cpu_wr         (cpu_wr),
        .cpu_addr       (cpu_addr),
        .cpu_wdata      (cpu_wdata),
        .cpu_rdata      (cpu_rdata),
        .out_bytes      (out_bytes),
        .out_drive      (out_drive)
    );

    // {output stream, output channel, word written}
    localparam logic [22:0] VEC [8] = '{
        {2'd0, 5'd3,  16'h002A},   // var, src s1 c10 (>= out ch)
        {2'd1, 5'd20, 16'h0044},   // var, src s2 c4  (< out ch)
        {2'd2, 5'd7,  16'h4067},   // const, src s3 c7
        {2'd3, 5'd0,  16'h401F},   // const, src s0 c31
        {2'd0, 5'd31, 16'hBFA5},   // proc 0xA5, reserved bits set
        {2'd1, 5'd31, 16'hC000},   // high impedance
        {2'd2, 5'd12, 16'h002A},   // var, same source as entry 0
        {2'd3, 5'd12, 16'h006C}    // var, src s3 c12 (== out ch)
    };

    int          n_run = 0;
    int          n_fail = 0;
    bit          finished = 0;
    logic [15:0] cm_model [8];
    bit          touched [8];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int f, input int s, input int c);
        return 8'((f * 29 + s * 67 + c * 7 + 3) & 255);
    endfunction

    function automatic logic [7:0] exp_byte(input logic [15:0] w, input int f, input int c);
        int ss, sc;
        ss = int'(w[6:5]);
        sc = int'(w[4:0]);
        case (w[15:14])
            2'b01:   return pat(f - 2, ss, sc);
            2'b00:   return (sc < c) ? pat(f, ss, sc) : pat(f - 1, ss, sc);
            2'b10:   return w[7:0];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] vaddr(input int e);
        return {1'b1, VEC[e][22:21], VEC[e][20:16]};
    endfunction

    task automatic cpu_write(input logic [7:0] a, input logic [15:0] d);
        cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
        @(posedge clk); #1;
        cpu_sel = 0; cpu_wr = 0;
    endtask

    task automatic cpu_read(input logic [7:0] a, output logic [15:0] d);
        cpu_sel = 1; cpu_wr = 0; cpu_addr = a;
        @(posedge clk); #1;
        cpu_sel = 0;
        d = cpu_rdata;
    endtask

    // mode: 0 none, 1 check entries, 2 expect all quiet, 3 expect some driven
    task automatic run_frame(input int f, input int nslots, input bit wr, input int wslot,
                             input logic [7:0] waddr, input logic [15:0] wdata,
                             input int mode, input string tag);
        int driven = 0;
        for (int e = 0; e < 8; e++) touched[e] = 0;
        for (int c = 0; c < nslots; c++) begin
            bit hit_now;
            frame_pulse = (c == 0);
            for (int s = 0; s < 4; s++) in_bytes[s*8 +: 8] = pat(f, s, c);
            hit_now = wr && (c == wslot);
            if (hit_now) begin
                cpu_sel = 1; cpu_wr = 1; cpu_addr = waddr; cpu_wdata = wdata;
            end
            @(posedge clk); #1;
            cpu_sel = 0; cpu_wr = 0; frame_pulse = 0;
            if (mode == 1) begin
                for (int e = 0; e < 8; e++) begin
                    if (int'(VEC[e][20:16]) == c) begin
                        int s;
                        string rq;
                        logic [15:0] w;
                        logic [7:0]  eb;
                        s = int'(VEC[e][22:21]);
                        w = cm_model[e];
                        case (w[15:14])
                            2'b00: rq = "R4";
                            2'b01: rq = "R3";
                            2'b10: rq = "R5";
                            default: rq = "R6";
                        endcase
                        if (e == 6) rq = "R12";
                        if (touched[e] || (hit_now && waddr == vaddr(e))) rq = "R11";
                        if (tag != "") rq = tag;
                        check(out_drive[s] == (w[15:14] != 2'b11), rq, 32'(out_drive[s]), 32'(w[15:14] != 2'b11));
                        eb = exp_byte(w, f, c);
                        check(out_bytes[s*8 +: 8] == eb, rq, 32'(out_bytes[s*8 +: 8]), 32'(eb));
                    end
                end
                if (c == 30) // R6: neighbour channel of the hi-z slot stays driven
                    check(out_drive[1] == 1'b1, "R6", 32'(out_drive[1]), 32'd1);
            end
            if (out_drive != 4'b0 || out_bytes != 32'b0) driven++;
            if (hit_now) begin
                for (int e = 0; e < 8; e++) begin
                    if (waddr == vaddr(e)) begin
                        cm_model[e] = wdata & 16'hC0FF;
                        touched[e]  = 1;
                    end
                end
            end
        end
        if (mode == 2) check(driven == 0, "R7", 32'(driven), 32'd0);
        if (mode == 3) check(driven > 0, "R7", 32'(driven), 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        rst = 1; frame_pulse = 0; in_bytes = '0; out_enable_pin = 0;
        cpu_sel = 0; cpu_wr = 0; cpu_addr = '0; cpu_wdata = '0;
        repeat (3) @(posedge clk); #1;
        rst = 0;

        // R1: reset state
        check(out_drive == 4'b0, "R1", 32'(out_drive), 32'd0);
        check(out_bytes == 32'b0, "R1", out_bytes, 32'd0);
        cpu_read(8'h00, rd);
        check(rd == 16'h0000, "R1", 32'(rd), 32'd0);
        cpu_read(8'h80, rd);
        check(rd == 16'h0000, "R1", 32'(rd), 32'd0);

        // R8: table walk, write then read back each word
        for (int e = 0; e < 8; e++) begin
            cpu_write(vaddr(e), VEC[e][15:0]);
            cpu_read(vaddr(e), rd);
            cm_model[e] = VEC[e][15:0] & 16'hC0FF;
            check(rd == cm_model[e], "R8", 32'(rd), 32'(cm_model[e]));
        end
        cpu_write(8'h00, 16'h0001);   // standby enable on

        run_frame(0, 32, 0, 0, 8'h00, 16'h0000, 0, "");
        run_frame(1, 32, 0, 0, 8'h00, 16'h0000, 0, "");
        run_frame(2, 32, 0, 0, 8'h00, 16'h0000, 1, "");
        run_frame(3, 32, 1, 31, 8'h00, 16'h0000, 1, "");   // standby off at end
        run_frame(4, 32, 0, 0, 8'h00, 16'h0000, 2, "");    // R7: both enables low
        out_enable_pin = 1;
        run_frame(5, 32, 1, 20, vaddr(4), 16'h805A, 1, ""); // R11: later slot sees new byte
        run_frame(6, 32, 1, 3, vaddr(0), 16'h8033, 1, "");  // R11: same slot keeps old word
        run_frame(7, 32, 1, 31, 8'h00, 16'h0001, 1, "");
        out_enable_pin = 0;
        run_frame(8, 16, 0, 0, 8'h00, 16'h0000, 3, "");    // R7: standby alone enables
        run_frame(9, 32, 0, 0, 8'h00, 16'h0000, 1, "R2");  // R2: early pulse restarts frame

        // R10: start bit without arm bit
        cpu_write(8'h00, 16'h0401);
        cpu_read(8'h00, rd);
        check(rd == 16'h0001, "R10", 32'(rd), 32'h0001);
        cpu_read(8'hB4, rd);
        check(rd == 16'h0044, "R10", 32'(rd), 32'h0044);

        // R9: block programming with pattern 11
        cpu_write(8'h00, 16'h0781);
        repeat (40) @(posedge clk); #1;
        check(out_drive == 4'b0, "R9", 32'(out_drive), 32'd0);
        cpu_read(8'h00, rd);
        check(rd == 16'h0001, "R9", 32'(rd), 32'h0001);
        cpu_read(8'h80, rd);
        check(rd == 16'hC000, "R9", 32'(rd), 32'hC000);
        cpu_read(8'h9F, rd);
        check(rd == 16'hC000, "R9", 32'(rd), 32'hC000);
        cpu_read(8'hFF, rd);
        check(rd == 16'hC000, "R9", 32'(rd), 32'hC000);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule